// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Interrupts

This block is a register-mapped general-purpose I/O controller. Its pins are split into equal banks. A pin's global number is its bank number times the bank size, plus its index inside the bank. Each pin has its own 32-bit control word, which sets:

- direction and driven level,
- a read-only copy of the synchronised pad level,
- the pull resistor choice,
- the interrupt trigger, built from three bits (on-high, on-low, edge/level),
- an interrupt enable and a sticky pending flag.

Each bank has a pending vector that software can read, a pad-select register and one interrupt line to its parent.

Pad inputs pass through a two-flop synchroniser. An edge is found by comparing the synchronised value with its value one cycle earlier. A pending flag is cleared by writing its control word with the pending bit set. A level trigger whose condition still holds sets the flag again on the next cycle.

The bank's pad-select register chooses, pin by pin, whether the pad is driven by the GPIO logic or by a peripheral. Register access goes through a single-cycle port: writes take effect at the clock edge, and reads are combinational from the address.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every control word reads 0, every bank pending vector reads 0, every pad-select register reads all ones, and every bank interrupt is low.
- R2: Word address {2'b00, pin} holds that pin's control word. The bit fields are:
  - bit0: output enable
  - bit1: output data
  - bit2: input level, read-only
  - bit3: interrupt enable
  - bit4: pending flag
  - bit5: trigger on high
  - bit6: trigger on low
  - bit7: edge (1) or level (0)
  - bit8: pull enable
  - bit9: pull up (1) or pull down (0)

  The writable fields read back as written. Bit2 shows the pad level after the second rising clock edge that follows a pad change.
- R3: A control-word write that has bit0 = 1 stores the interrupt enable as 0, whatever value bit3 carries.
- R4: In edge mode (bit7 = 1), the trigger bits select the edge:
  - bit5 = 1, bit6 = 0: rising edge
  - bit5 = 0, bit6 = 1: falling edge
  - both bits set: either edge

  A matching pad edge sets the pending flag, which reads as 1 after the third rising clock edge that follows the pad change.
- R5: In level mode (bit7 = 0), bit5 = 1 sets the flag while the pad is high and bit6 = 1 sets it while the pad is low. A clear applied while the level condition holds reads 0 right after the write edge and 1 one cycle later.
- R6: Writing a control word with bit4 = 1 clears that pin's pending flag at the write edge; the clear wins over a trigger in the same cycle. Writing bit4 = 0 leaves the flag unchanged, so a write with bit3 = 0 and bit4 = 1 both masks the pin and clears it.
- R7: Word address {2'b01, bank} reads the bank's pending vector, with bit n as the flag of pin n of that bank. Writes to this address are ignored.
- R8: bank_irq[b] is high exactly when some pin of bank b has both its pending flag and its interrupt enable set. A pending flag with the enable clear does not raise the line.
- R9: Word address {2'b10, bank} is the read/write pad-select register. Bit n = 1 makes pad_out and pad_oe of pin n follow the output data and output enable fields. Bit n = 0 passes periph_out and periph_oe through instead.
- R10: pad_pu of a pin is high when pull enable and pull up are both set. pad_pd is high when pull enable is set and pull up is clear. Both are low when pull enable is clear.
- R11: Pin p of bank b appears at control address b*PINS_PER_BANK+p, at bit p of its bank's pending vector, and on bank_irq[b].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word address: region in the top two bits, index below |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| periph_out | input | NUM_PINS | Peripheral output data per pin |
| periph_oe | input | NUM_PINS | Peripheral output enable per pin |
| pad_out | output | NUM_PINS | Pad output data |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pu | output | NUM_PINS | Pull-up request |
| pad_pd | output | NUM_PINS | Pull-down request |
| bank_irq | output | NUM_BANKS | One interrupt line per bank |

## Verification
The random part drives a pin from a stable level v0 to a new level v1 under each of the five trigger encodings, after arming and clearing the pin. This sorts the edge modes apart by direction, and sets the level modes apart from the edge modes, because a level condition that held at v0 leaves the flag set even when no edge occurs. Directed cases pin down:
- the two-edge and three-edge latencies,
- the one-cycle re-set after a level clear,
- a pending flag that is hidden from the line while disabled,
- a write to the pending vector that has no effect,
- the pad-select handover.

Pins in both banks are used, so the global numbering and the per-bank line routing are both exercised.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Control word bit positions (software-visible layout)
  localparam int F_OE   = 0;
  localparam int F_DO   = 1;
  localparam int F_DI   = 2;
  localparam int F_IEN  = 3;
  localparam int F_STS  = 4;
  localparam int F_HI   = 5;
  localparam int F_LO   = 6;
  localparam int F_EDGE = 7;
  localparam int F_PEN  = 8;
  localparam int F_PUP  = 9;
  localparam int CTRL_W = 10;

  typedef enum logic [1:0] {
    RG_CTRL  = 2'd0,
    RG_STAT  = 2'd1,
    RG_PADEN = 2'd2,
    RG_NONE  = 2'd3
  } region_e;

  typedef struct packed {
    logic pup;
    logic pen;
    logic edge_md;
    logic lo;
    logic hi;
    logic ien;
    logic dout;
    logic oe;
  } pin_cfg_t;

  // Trigger decision from the stored config, current and previous synced level
  function automatic logic trig_hit(input pin_cfg_t c, input logic cur, input logic prv);
    if (c.edge_md) return (c.hi & cur & ~prv) | (c.lo & ~cur & prv);
    return (c.hi & cur) | (c.lo & ~cur);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
  import gpio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              din,
  output logic              oe,
  output logic              dout,
  output logic              ien,
  output logic              pen,
  output logic              pup,
  output logic              sts,
  output logic [DATA_W-1:0] rd_word
);
  pin_cfg_t cfg_q, cfg_d;
  logic     cfg_en;
  logic     sts_q, sts_d;
  logic     prev_q;
  logic     hit;
  logic     ack;

  // next-state: configuration
  always_comb begin
    cfg_en       = wr_sel;
    cfg_d.oe     = wdata[F_OE];
    cfg_d.dout   = wdata[F_DO];
    cfg_d.ien    = wdata[F_IEN] & ~wdata[F_OE];
    cfg_d.hi     = wdata[F_HI];
    cfg_d.lo     = wdata[F_LO];
    cfg_d.edge_md = wdata[F_EDGE];
    cfg_d.pen    = wdata[F_PEN];
    cfg_d.pup    = wdata[F_PUP];
  end

  // next-state: pending flag, clear wins over a same-cycle trigger
  always_comb begin
    hit   = trig_hit(cfg_q, din, prev_q);
    ack   = wr_sel & wdata[F_STS];
    sts_d = ack ? 1'b0 : (sts_q | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      sts_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      sts_q  <= sts_d;
      prev_q <= din;
    end
  end

  always_comb begin
    rd_word         = '0;
    rd_word[F_OE]   = cfg_q.oe;
    rd_word[F_DO]   = cfg_q.dout;
    rd_word[F_DI]   = din;
    rd_word[F_IEN]  = cfg_q.ien;
    rd_word[F_STS]  = sts_q;
    rd_word[F_HI]   = cfg_q.hi;
    rd_word[F_LO]   = cfg_q.lo;
    rd_word[F_EDGE] = cfg_q.edge_md;
    rd_word[F_PEN]  = cfg_q.pen;
    rd_word[F_PUP]  = cfg_q.pup;
  end

  assign oe   = cfg_q.oe;
  assign dout = cfg_q.dout;
  assign ien  = cfg_q.ien;
  assign pen  = cfg_q.pen;
  assign pup  = cfg_q.pup;
  assign sts  = sts_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [PINS-1:0]             pad_in,
  input  logic [PINS-1:0]             periph_out,
  input  logic [PINS-1:0]             periph_oe,
  input  logic [PINS-1:0]             ctrl_wr,
  input  logic                        paden_wr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [PINS-1:0]             pad_out,
  output logic [PINS-1:0]             pad_oe,
  output logic [PINS-1:0]             pad_pu,
  output logic [PINS-1:0]             pad_pd,
  output logic                        irq,
  output logic [PINS-1:0]             sts_vec,
  output logic [PINS-1:0]             ien_vec,
  output logic [PINS-1:0]             oe_vec,
  output logic [PINS-1:0]             paden,
  output logic [PINS-1:0][DATA_W-1:0] ctrl_rd
);
  logic [PINS-1:0] din_sync;
  logic [PINS-1:0] dout_vec, pen_vec, pup_vec;
  logic [PINS-1:0] paden_q, paden_d;
  logic            paden_en;

  gpio_sync #(.WIDTH(PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (din_sync)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    gpio_pin #(.DATA_W(DATA_W)) u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (ctrl_wr[i]),
      .wdata   (wdata[CTRL_W-1:0]),
      .din     (din_sync[i]),
      .oe      (oe_vec[i]),
      .dout    (dout_vec[i]),
      .ien     (ien_vec[i]),
      .pen     (pen_vec[i]),
      .pup     (pup_vec[i]),
      .sts     (sts_vec[i]),
      .rd_word (ctrl_rd[i])
    );
  end

  always_comb begin
    paden_en = paden_wr;
    paden_d  = wdata[PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        paden_q <= '1;
    else if (paden_en) paden_q <= paden_d;
  end

  always_comb begin
    pad_out = (paden_q & dout_vec) | (~paden_q & periph_out);
    pad_oe  = (paden_q & oe_vec)   | (~paden_q & periph_oe);
    pad_pu  = pen_vec & pup_vec;
    pad_pd  = pen_vec & ~pup_vec;
    irq     = |(sts_vec & ien_vec);
  end

  assign paden = paden_q;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int PINS_PER_BANK = 32,
  parameter int DATA_W        = 32,
  localparam int NUM_PINS     = NUM_BANKS * PINS_PER_BANK,
  localparam int IDX_W        = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W       = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [NUM_PINS-1:0]  pad_in,
  input  logic [NUM_PINS-1:0]  periph_out,
  input  logic [NUM_PINS-1:0]  periph_oe,
  output logic [NUM_PINS-1:0]  pad_out,
  output logic [NUM_PINS-1:0]  pad_oe,
  output logic [NUM_PINS-1:0]  pad_pu,
  output logic [NUM_PINS-1:0]  pad_pd,
  output logic [NUM_BANKS-1:0] bank_irq
);
  region_e                               region;
  logic [IDX_W-1:0]                      idx;
  logic [NUM_PINS-1:0]                   ctrl_wr;
  logic [NUM_BANKS-1:0]                  paden_wr;
  logic [NUM_PINS-1:0][DATA_W-1:0]       ctrl_rd_all;
  logic [NUM_BANKS-1:0][PINS_PER_BANK-1:0] sts_bank;
  logic [NUM_BANKS-1:0][PINS_PER_BANK-1:0] paden_bank;
  logic [NUM_PINS-1:0]                   sts_flat;
  logic [NUM_PINS-1:0]                   ien_flat;
  logic [NUM_PINS-1:0]                   oe_flat;

  assign region = region_e'(reg_addr[ADDR_W-1 -: 2]);
  assign idx    = reg_addr[IDX_W-1:0];

  // write decode
  always_comb begin
    for (int p = 0; p < NUM_PINS; p++)
      ctrl_wr[p] = reg_wr && (region == RG_CTRL) && (idx == IDX_W'(p));
    for (int b = 0; b < NUM_BANKS; b++)
      paden_wr[b] = reg_wr && (region == RG_PADEN) && (idx == IDX_W'(b));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * PINS_PER_BANK;
    gpio_bank #(.PINS(PINS_PER_BANK), .DATA_W(DATA_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .pad_in     (pad_in[LO +: PINS_PER_BANK]),
      .periph_out (periph_out[LO +: PINS_PER_BANK]),
      .periph_oe  (periph_oe[LO +: PINS_PER_BANK]),
      .ctrl_wr    (ctrl_wr[LO +: PINS_PER_BANK]),
      .paden_wr   (paden_wr[b]),
      .wdata      (reg_wdata),
      .pad_out    (pad_out[LO +: PINS_PER_BANK]),
      .pad_oe     (pad_oe[LO +: PINS_PER_BANK]),
      .pad_pu     (pad_pu[LO +: PINS_PER_BANK]),
      .pad_pd     (pad_pd[LO +: PINS_PER_BANK]),
      .irq        (bank_irq[b]),
      .sts_vec    (sts_bank[b]),
      .ien_vec    (ien_flat[LO +: PINS_PER_BANK]),
      .oe_vec     (oe_flat[LO +: PINS_PER_BANK]),
      .paden      (paden_bank[b]),
      .ctrl_rd    (ctrl_rd_all[LO +: PINS_PER_BANK])
    );
    assign sts_flat[LO +: PINS_PER_BANK] = sts_bank[b];
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (region)
      RG_CTRL: begin
        for (int p = 0; p < NUM_PINS; p++)
          if (idx == IDX_W'(p)) reg_rdata = ctrl_rd_all[p];
      end
      RG_STAT: begin
        for (int b = 0; b < NUM_BANKS; b++)
          if (idx == IDX_W'(b)) reg_rdata = DATA_W'(sts_bank[b]);
      end
      RG_PADEN: begin
        for (int b = 0; b < NUM_BANKS; b++)
          if (idx == IDX_W'(b)) reg_rdata = DATA_W'(paden_bank[b]);
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int PINS_PER_BANK = 32,
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  localparam int NUM_PINS     = NUM_BANKS * PINS_PER_BANK
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic                 reg_wr,
  input logic [DATA_W-1:0]    reg_wdata,
  input logic [NUM_BANKS-1:0] bank_irq,
  input logic [NUM_PINS-1:0]  sts_flat,
  input logic [NUM_PINS-1:0]  ien_flat,
  input logic [NUM_PINS-1:0]  oe_flat
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
    localparam logic [ADDR_W-1:0] PADDR = ADDR_W'(p);
    logic ack_wr;
    assign ack_wr = reg_wr && (reg_addr == PADDR) && reg_wdata[F_STS];

    // R6: a clearing write leaves the flag low after the edge
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr |=> !sts_flat[p]);

    // R6: a pending flag holds until it is cleared
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_flat[p] && !ack_wr) |=> sts_flat[p]);

    // R3: an output pin never keeps its interrupt enabled
    a_r3_out_no_ien: assert property (@(posedge clk) disable iff (!rst_n)
      !(oe_flat[p] && ien_flat[p]));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    localparam int LO = b * PINS_PER_BANK;
    // R8: line only with an enabled pending pin
    a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      bank_irq[b] |-> |(sts_flat[LO +: PINS_PER_BANK] & ien_flat[LO +: PINS_PER_BANK]));
    // R8: an enabled pending pin raises the line
    a_r8_source_raises: assert property (@(posedge clk) disable iff (!rst_n)
      |(sts_flat[LO +: PINS_PER_BANK] & ien_flat[LO +: PINS_PER_BANK]) |-> bank_irq[b]);
  end
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
  .NUM_BANKS     (NUM_BANKS),
  .PINS_PER_BANK (PINS_PER_BANK),
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .bank_irq  (bank_irq),
  .sts_flat  (sts_flat),
  .ien_flat  (ien_flat),
  .oe_flat   (oe_flat)
);

// File: tb/test_gpio_ctrl.sv
`timescale 1ns/1ps
module test_gpio_ctrl;
  localparam int NB  = 2;
  localparam int PPB = 32;
  localparam int NP  = NB * PPB;
  localparam int AW  = 8;

  localparam logic [31:0] B_OE = 32'h1, B_DO = 32'h2, B_DI = 32'h4, B_IEN = 32'h8,
                          B_STS = 32'h10, B_HI = 32'h20, B_LO = 32'h40, B_EDGE = 32'h80,
                          B_PEN = 32'h100, B_PUP = 32'h200;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] reg_addr;
  logic          reg_wr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pad_in, periph_out, periph_oe;
  logic [NP-1:0] pad_out, pad_oe, pad_pu, pad_pd;
  logic [NB-1:0] bank_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_ctrl #(.NUM_BANKS(NB), .PINS_PER_BANK(PPB), .DATA_W(32)) i_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .periph_out(periph_out), .periph_oe(periph_oe), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd), .bank_irq(bank_irq)
  );

  function automatic logic [AW-1:0] a_ctrl(input int p);  return AW'(p); endfunction
  function automatic logic [AW-1:0] a_stat(input int b);  return AW'(64 + b); endfunction
  function automatic logic [AW-1:0] a_paden(input int b); return AW'(128 + b); endfunction

  // trigger bits for mode 0..4: rise, fall, both, level low, level high
  function automatic logic [31:0] mode_bits(input int m);
    case (m)
      0: return B_HI | B_EDGE;
      1: return B_LO | B_EDGE;
      2: return B_HI | B_LO | B_EDGE;
      3: return B_LO;
      default: return B_HI;
    endcase
  endfunction

  // expected pending flag after arming at level v0 then moving to v1
  function automatic logic exp_flag(input int m, input logic v0, input logic v1);
    case (m)
      0: return !v0 && v1;
      1: return v0 && !v1;
      2: return v0 != v1;
      3: return !v0 || !v1;
      default: return v0 || v1;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_wdata = '0;
    pad_in = '0; periph_out = '0; periph_oe = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(a_ctrl(0), d);  check("R1 ctrl0", d, 32'h0);
    rd(a_ctrl(63), d); check("R1 ctrl63", d, 32'h0);
    rd(a_stat(1), d);  check("R1 stat1", d, 32'h0);
    rd(a_paden(0), d); check("R1 paden0", d, 32'hFFFF_FFFF);
    check("R1 irq", 32'(bank_irq), 32'h0);

    // R2 field readback (DI write ignored), R9/R10 pad outputs in GPIO mode
    wr(a_ctrl(5), B_OE | B_DO | B_DI | B_HI | B_LO | B_EDGE | B_PEN | B_PUP);
    rd(a_ctrl(5), d); check("R2 readback", d, 32'h3E3);
    check("R9 pad_out5", 32'(pad_out[5]), 32'h1);
    check("R9 pad_oe5", 32'(pad_oe[5]), 32'h1);
    check("R10 pu5", 32'(pad_pu[5]), 32'h1);
    check("R10 pd5", 32'(pad_pd[5]), 32'h0);

    // R2 input level after two edges, R4 both-edge flag after three
    pad_in[5] = 1'b1;
    tick(2);
    rd(a_ctrl(5), d);
    check("R2 din", d & B_DI, B_DI);
    check("R4 not yet", d & B_STS, 32'h0);
    tick(1);
    rd(a_ctrl(5), d); check("R4 both rise", d & B_STS, B_STS);
    rd(a_stat(0), d); check("R11 stat0 bit5", d, 32'h20);

    // R9 hand pin 5 to the peripheral
    wr(a_paden(0), 32'hFFFF_FFDF);
    rd(a_paden(0), d); check("R9 paden rb", d, 32'hFFFF_FFDF);
    check("R9 periph out0", 32'(pad_out[5]), 32'h0);
    check("R9 periph oe0", 32'(pad_oe[5]), 32'h0);
    periph_out[5] = 1'b1; periph_oe[5] = 1'b1;
    #0.5;
    check("R9 periph out1", 32'(pad_out[5]), 32'h1);
    check("R9 periph oe1", 32'(pad_oe[5]), 32'h1);
    wr(a_paden(0), 32'hFFFF_FFFF);
    periph_out = '0; periph_oe = '0;
    wr(a_ctrl(5), B_STS);
    pad_in[5] = 1'b0;

    // R3 output forces enable off
    wr(a_ctrl(7), B_OE | B_IEN);
    rd(a_ctrl(7), d); check("R3 oe drops ien", d, B_OE);
    wr(a_ctrl(7), B_IEN);
    rd(a_ctrl(7), d); check("R3 input keeps ien", d, B_IEN);

    // R10 pull-down and no pull
    wr(a_ctrl(9), B_PEN);
    check("R10 pd9", 32'(pad_pd[9]), 32'h1);
    check("R10 pu9", 32'(pad_pu[9]), 32'h0);
    wr(a_ctrl(9), 32'h0);
    check("R10 none", 32'({pad_pu[9], pad_pd[9]}), 32'h0);

    // R8 pending without enable keeps line low, then enabling raises it
    wr(a_ctrl(33), B_HI | B_EDGE);
    pad_in[33] = 1'b1;
    tick(3);
    rd(a_stat(1), d); check("R11 stat1 bit1", d, 32'h2);
    check("R8 masked", 32'(bank_irq), 32'h0);
    wr(a_ctrl(33), B_HI | B_EDGE | B_IEN);
    check("R8 enabled", 32'(bank_irq), 32'h2);

    // R7 write to pending vector ignored
    wr(a_stat(1), 32'hFFFF_FFFF);
    rd(a_stat(1), d); check("R7 stat write ignored", d, 32'h2);
    // R6 write with flag bit 0 keeps it
    wr(a_ctrl(33), B_HI | B_EDGE | B_IEN);
    rd(a_ctrl(33), d); check("R6 keep", d & B_STS, B_STS);
    // R6 mask + clear
    wr(a_ctrl(33), B_STS);
    rd(a_ctrl(33), d); check("R6 mask clear", d, B_DI);
    check("R8 low after mask", 32'(bank_irq), 32'h0);
    pad_in[33] = 1'b0;

    // R5 level high re-sets one cycle after a clear
    pad_in[40] = 1'b1;
    wr(a_ctrl(40), B_HI | B_IEN);
    tick(3);
    check("R5 level irq", 32'(bank_irq), 32'h2);
    wr(a_ctrl(40), B_HI | B_IEN | B_STS);
    rd(a_ctrl(40), d); check("R5 cleared", d & B_STS, 32'h0);
    tick(1);
    rd(a_ctrl(40), d); check("R5 re-set", d & B_STS, B_STS);
    pad_in[40] = 1'b0;
    tick(3);
    wr(a_ctrl(40), B_HI | B_IEN | B_STS);
    tick(2);
    rd(a_ctrl(40), d); check("R5 stays clear", d & B_STS, 32'h0);
    wr(a_ctrl(40), B_STS);
    wr(a_ctrl(7), B_STS);

    // R4/R5/R8/R11 random trigger sweep
    void'($urandom(32'h5EED_1234));
    for (int it = 0; it < 60; it++) begin
      int   p, m;
      logic v0, v1, e;
      p  = int'($urandom_range(NP - 1));
      m  = int'($urandom_range(4));
      v0 = 1'($urandom_range(1));
      v1 = 1'($urandom_range(1));
      pad_in[p] = v0;
      tick(4);
      wr(a_ctrl(p), mode_bits(m) | B_IEN | B_STS);
      pad_in[p] = v1;
      tick(3);
      e = exp_flag(m, v0, v1);
      rd(a_ctrl(p), d);
      check("R4 R5 random flag", d & B_STS, e ? B_STS : 32'h0);
      check("R8 R11 random irq", 32'(bank_irq[p / PPB]), 32'(e));
      wr(a_ctrl(p), B_STS);
    end

    finish_run();
  end
endmodule